// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects a simple internal request port to an external bus for SRAM-like devices. On that bus, address and data share one 16-bit set of lines. An internal request carries a byte address, write data, a size flag (byte or halfword), and a read or write strobe. The block runs one external cycle for each accepted request and returns a one-cycle done pulse. For reads, the read data is valid in the same cycle as the done pulse.

Each external cycle has three parts:
- **Address phase.** One cycle in which the address is driven on the shared lines and the latch strobe is high.
- **Data phase.** A fixed number of cycles with the read strobe or the byte write strobes asserted.
- **Turnaround.** One cycle in which every strobe and chip select is released.

A configuration input selects a 16-bit or an 8-bit external width. In 16-bit mode:
- The byte address is halved before it is driven out.
- Writes light only the byte lanes they touch.
- Every read fetches a full halfword, and the controller picks out the requested byte.

The top two internal address bits choose one of four active-low chip selects.

Top module: `muxbus_ctrl`

## Requirements
- R1: After reset the block is idle: busy=0, done=0, ale=0, rd_n=wrh_n=wrl_n=1, cs_n=4'b1111, ad_oe=0.
- R2: A request is sampled at a clock edge while busy=0. In the next cycle ale=1 and ad_oe=1 for exactly one cycle. Then come DATA_CYCLES cycles with a strobe asserted. Then one turnaround cycle with all strobes and chip selects high and done=1. So done appears in the (DATA_CYCLES+2)th cycle after the request, and busy is 1 from the address cycle through the turnaround.
- R3: The external 24-bit address is {a_hi, ad_out} while ale=1. In 16-bit mode it equals byte address bits [24:1], so 0x0042 gives 0x0021. In 8-bit mode it equals byte address bits [23:0].
- R4: The request's address bits [25:24] give an index k. Only cs_n[k] is low, and it stays low through the address and data phases.
- R5: 16-bit mode writes:
  - An even byte write asserts only wrl_n, with the data on ad_out[7:0].
  - An odd byte write asserts only wrh_n, with the data on ad_out[15:8].
  - A halfword write asserts both strobes, with wdata[15:8] on the high lane and wdata[7:0] on the low lane.
- R6: In 8-bit mode every write asserts only wrl_n, with wdata[7:0] on ad_out[7:0], whatever the size flag is. wrh_n never asserts in this mode.
- R7: During a read data phase, rd_n=0, ad_oe=0 and no write strobe is asserted. ad_in is sampled on the last data-phase cycle, and rdata holds the result while done=1.
- R8: Read data steering:
  - A 16-bit halfword read returns ad_in[15:0].
  - A 16-bit byte read returns ad_in[15:8] when address bit 0 is 1, and ad_in[7:0] when it is 0.
  - An 8-bit read returns ad_in[7:0].
  - For byte reads and 8-bit reads, rdata[15:8] is 0.
- R9: A request presented while busy=1 is ignored and produces no external cycle. When req_rd and req_wr are both 1, a read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | 1 | 1 selects a 16-bit external bus, 0 selects 8-bit; captured with each request |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request |
| req_half | input | 1 | 1 for a halfword access, 0 for a byte access |
| req_addr | input | 26 | Internal byte address; bits [25:24] select the chip |
| req_wdata | input | 16 | Write data; a byte write uses bits [7:0] |
| busy | output | 1 | Cycle in progress; new requests are ignored |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid with done |
| ad_out | output | 16 | Shared address/data lines, driven value |
| ad_oe | output | 1 | Drive enable for ad_out; 0 releases the lines |
| ad_in | input | 16 | Shared address/data lines, sampled value |
| ale | output | 1 | Address latch strobe |
| a_hi | output | 8 | Upper external address bits [23:16] |
| rd_n | output | 1 | Active-low read strobe |
| wrh_n | output | 1 | Active-low high-byte write strobe |
| wrl_n | output | 1 | Active-low low-byte write strobe |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The assertions assume that cfg_wide does not change in the middle of a request. They also assume that the external device only drives ad_in while the block has released the lines. Requests may be pulsed at any time, including while busy, and the assertions are written to tolerate that. The stimulus changes cfg_wide only between transactions, while the block is idle. The bench's device model puts data on ad_in only while rd_n is low. Some requests are deliberately presented during a busy cycle, some with both strobes set, so the ignore and read-priority rules are exercised without ever breaking those assumptions.

// File: rtl/muxbus_ctrl.sv
`timescale 1ns/1ps
module muxbus_ctrl #(
  parameter int ADDR_W      = 26,
  parameter int DATA_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic              req_half,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rdata,
  output logic [15:0]       ad_out,
  output logic              ad_oe,
  input  logic [15:0]       ad_in,
  output logic              ale,
  output logic [ADDR_W-19:0] a_hi,
  output logic              rd_n,
  output logic              wrh_n,
  output logic              wrl_n,
  output logic [3:0]        cs_n
);
  localparam int EXT_W = ADDR_W - 2;
  localparam int CW    = (DATA_CYCLES < 2) ? 1 : $clog2(DATA_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(DATA_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_TURN} state_t;

  state_t            st;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] r_addr;
  logic [15:0]       r_wdata;
  logic              r_half, r_rd, r_wide;
  logic [15:0]       rdata_q;

  wire accept   = (st == S_IDLE) && (req_rd || req_wr);
  wire in_data  = (st == S_DATA);
  wire last_dat = in_data && (cnt == LAST);
  wire active   = (st == S_ADDR) || in_data;

  wire [EXT_W-1:0] ext_addr = r_wide ? r_addr[EXT_W:1] : r_addr[EXT_W-1:0];
  wire [1:0]       cs_sel   = r_addr[ADDR_W-1:ADDR_W-2];

  wire lane_lo = !r_wide || r_half || !r_addr[0];
  wire lane_hi =  r_wide && (r_half || r_addr[0]);

  wire [15:0] wr_lanes = !r_wide ? {8'h00, r_wdata[7:0]} :
                         r_half  ? r_wdata : {r_wdata[7:0], r_wdata[7:0]};

  wire [15:0] rd_steer = !r_wide ? {8'h00, ad_in[7:0]} :
                         r_half  ? ad_in :
                         r_addr[0] ? {8'h00, ad_in[15:8]} : {8'h00, ad_in[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      r_addr  <= '0;
      r_wdata <= '0;
      r_half  <= 1'b0;
      r_rd    <= 1'b0;
      r_wide  <= 1'b0;
      rdata_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st      <= S_ADDR;
          r_addr  <= req_addr;
          r_wdata <= req_wdata;
          r_half  <= req_half;
          r_rd    <= req_rd;
          r_wide  <= cfg_wide;
        end
        S_ADDR: begin
          st  <= S_DATA;
          cnt <= '0;
        end
        S_DATA: begin
          if (last_dat) begin
            st <= S_TURN;
            if (r_rd) rdata_q <= rd_steer;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy   = (st != S_IDLE);
  assign done   = (st == S_TURN);
  assign rdata  = rdata_q;
  assign ale    = (st == S_ADDR);
  assign ad_oe  = ale || (in_data && !r_rd);
  assign ad_out = ale ? ext_addr[15:0] : wr_lanes;
  assign a_hi   = ext_addr[EXT_W-1:16];
  assign rd_n   = !(in_data && r_rd);
  assign wrl_n  = !(in_data && !r_rd && lane_lo);
  assign wrh_n  = !(in_data && !r_rd && lane_hi);
  assign cs_n   = active ? ~(4'b0001 << cs_sel) : 4'b1111;

  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  p_ale_then_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!rd_n || !wrl_n || !wrh_n));
  p_cs_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wrl_n || !wrh_n) |-> $onehot(~cs_n));
  p_cs_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n == 4'b1111));
  p_narrow_no_wrh_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrh_n |-> r_wide);
  p_read_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!ad_oe && wrl_n && wrh_n));
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: tb/test_muxbus_ctrl.sv
`timescale 1ns/1ps
module test_muxbus_ctrl;
  localparam int N = 2;

  logic clk = 0, rst_n = 0;
  logic cfg_wide = 1, req_rd = 0, req_wr = 0, req_half = 0;
  logic [25:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, ad_oe, ale, rd_n, wrh_n, wrl_n;
  logic [15:0] rdata, ad_out, ad_in;
  logic [7:0] a_hi;
  logic [3:0] cs_n;

  always #2 clk = ~clk;

  muxbus_ctrl #(.ADDR_W(26), .DATA_CYCLES(N)) i_muxbus_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .req_rd(req_rd), .req_wr(req_wr),
    .req_half(req_half), .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .done(done), .rdata(rdata), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ale(ale), .a_hi(a_hi), .rd_n(rd_n), .wrh_n(wrh_n), .wrl_n(wrl_n), .cs_n(cs_n));

  typedef struct packed {
    logic        rd;
    logic [23:0] ea;
    logic [3:0]  cs;
    logic        wl, wh;
    logic [7:0]  lo, hi;
    logic [15:0] rdat;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0, accepted = 0, ale_cnt = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input logic [23:0] a);
    return a[15:0] ^ 16'hA5C3;
  endfunction

  // device model
  logic [23:0] lat_ea;
  logic [3:0]  lat_cs;
  logic saw_wl, saw_wh, bad_oe, bad_cs;
  logic [7:0] cap_lo, cap_hi;
  assign ad_in = rd_n ? 16'h0000 : pat(lat_ea);

  always @(posedge clk) begin
    if (ale) begin
      ale_cnt <= ale_cnt + 1;
      lat_ea <= {a_hi, ad_out};
      lat_cs <= cs_n;
      saw_wl <= 0; saw_wh <= 0; bad_oe <= 0; bad_cs <= 0;
    end else begin
      if (!wrl_n) begin saw_wl <= 1; cap_lo <= ad_out[7:0]; end
      if (!wrh_n) begin saw_wh <= 1; cap_hi <= ad_out[15:8]; end
      if (!rd_n && ad_oe) bad_oe <= 1;
      if ((!rd_n || !wrl_n || !wrh_n) && cs_n != lat_cs) bad_cs <= 1;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      if (q.size() == 0) chk(0, "R9 unexpected done", 1, 0);
      else begin
        e = q.pop_front();
        chk(lat_ea == e.ea, "R3 address", lat_ea, e.ea);
        chk(lat_cs == e.cs && !bad_cs, "R4 chip select", lat_cs, e.cs);
        chk(cs_n == 4'hF && rd_n && wrl_n && wrh_n, "R2 turnaround idle", {cs_n, rd_n, wrl_n, wrh_n}, 7'h7F);
        if (e.rd) begin
          chk(!saw_wl && !saw_wh && !bad_oe, "R7 read strobes/release", {saw_wl, saw_wh, bad_oe}, 0);
          chk(rdata == e.rdat, "R8 read data", rdata, e.rdat);
        end else begin
          chk(saw_wl == e.wl && saw_wh == e.wh, "R5 R6 write strobes", {saw_wl, saw_wh}, {e.wl, e.wh});
          if (e.wl) chk(cap_lo == e.lo, "R5 R6 low lane", cap_lo, e.lo);
          if (e.wh) chk(cap_hi == e.hi, "R5 high lane", cap_hi, e.hi);
        end
      end
    end
  end

  task automatic xfer(input logic wide, input logic rd, input logic wr, input logic half,
                      input logic [25:0] a, input logic [15:0] wd, input logic poke);
    exp_t e;
    logic [15:0] p;
    logic isrd = rd;
    e.rd = isrd;
    e.ea = wide ? a[24:1] : a[23:0];
    e.cs = ~(4'b0001 << a[25:24]);
    e.wl = !wide || half || !a[0];
    e.wh = wide && (half || a[0]);
    e.lo = wd[7:0];
    e.hi = half ? wd[15:8] : wd[7:0];
    p = pat(e.ea);
    e.rdat = !wide ? {8'h00, p[7:0]} : half ? p : a[0] ? {8'h00, p[15:8]} : {8'h00, p[7:0]};
    @(negedge clk);
    cfg_wide = wide; req_rd = rd; req_wr = wr; req_half = half; req_addr = a; req_wdata = wd;
    q.push_back(e);
    accepted++;
    @(negedge clk);
    req_rd = 0; req_wr = 0;
    chk(busy && ale && ad_oe, "R2 address phase", {busy, ale, ad_oe}, 3'b111);
    if (poke) begin req_rd = 1; req_wr = 1; req_addr = 26'h3FFFFFF; end
    @(negedge clk);
    req_rd = 0; req_wr = 0;
    repeat (N - 1) @(negedge clk);
    chk(!done && busy, "R2 done not early", done, 0);
    @(negedge clk);
    chk(done && busy, "R2 done timing", done, 1);
    @(negedge clk);
    chk(!busy && !done, "R2 back to idle", busy, 0);
  endtask

  initial begin
    #20000;
    chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ale && rd_n && wrh_n && wrl_n && cs_n == 4'hF && !ad_oe,
        "R1 reset state", {busy, done, ale, rd_n, wrh_n, wrl_n, cs_n, ad_oe}, 11'b00011111110);
    rst_n = 1;
    chk(!busy && !done && !ale && rd_n && wrh_n && wrl_n && cs_n == 4'hF && !ad_oe,
        "R1 idle after reset", {busy, ale, cs_n}, 6'h0F);
    // R3: 0x0042 -> 0x0021 in 16-bit mode
    xfer(1, 1, 0, 1, 26'h0000042, 16'h0, 0);
    // R5 writes
    xfer(1, 0, 1, 0, 26'h1000042, 16'h00AB, 0);
    xfer(1, 0, 1, 0, 26'h2123457, 16'h00CD, 0);
    xfer(1, 0, 1, 1, 26'h3ABCDE0, 16'h1234, 0);
    // R8 byte reads
    xfer(1, 1, 0, 0, 26'h0001234, 16'h0, 0);
    xfer(1, 1, 0, 0, 26'h2FFFFFF, 16'h0, 0);
    // R6 / R8 8-bit mode
    xfer(0, 0, 1, 1, 26'h1345679, 16'hBEEF, 0);
    xfer(0, 0, 1, 0, 26'h0000042, 16'h0077, 0);
    xfer(0, 1, 0, 1, 26'h3800001, 16'h0, 0);
    // R9: both strobes -> read; poke while busy ignored
    xfer(1, 1, 1, 1, 26'h1000100, 16'h5555, 1);
    xfer(0, 0, 1, 0, 26'h2000010, 16'h00EE, 1);
    repeat (4) @(negedge clk);
    chk(ale_cnt == accepted, "R9 busy requests ignored", ale_cnt, accepted);
    chk(q.size() == 0, "R2 all cycles completed", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule